// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block takes one interrupt request at a time from an external arbiter. It holds the request until the instruction now running reports completion. It then counts out an interrupt sequence whose length depends on the low bits of the vector address and the stack pointer, on the bus width and on the source kind. At the end of the sequence it updates the processor's 3-bit interrupt priority level (IPL).

The arbiter raises `req_valid` with the source kind, priority and parity bits. It keeps them steady until it sees `busy` high. The pipeline raises `instr_done` when the current instruction retires. One cycle after the sequence ends, `seq_done` pulses and the new IPL appears on `ipl`.

The source kind fixes the IPL rule. A maskable source loads its own priority. A fixed-level source, such as a watchdog, NMI, clock-failure or supply-monitor event, loads 7. Software, address-match, single-step and debug sources leave the level as it was.

Top module: `int_accept_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy` and `seq_done` are 0 and `ipl` is 0. A reset during a sequence abandons it.
- R2: A `req_valid` sampled high while `busy` is low makes `busy` high from the next cycle. The counted sequence starts only at the first edge, after acceptance, at which `instr_done` is sampled high. With no accepted request, `instr_done` has no effect.
- R3: With `bus_narrow`=0, the sequence lasts 18 cycles plus 1 for each of `vec_lsb` and `sp_lsb` that is 1. The count runs from the edge that samples `instr_done` to the edge that raises `seq_done`.
- R4: With `bus_narrow`=1, the base length is 20 cycles whatever the parity bits are.
- R5: Source kind 5 (debug) adds 2 cycles to the base length. Kinds 3 (address match) and 4 (single step) add 1 cycle.
- R6: Kind 0 (maskable) loads `ipl` with `req_prio`.
- R7: Kind 1 (fixed level) loads `ipl` with 7, whatever `req_prio` is.
- R8: Kinds 2 (software), 3, 4 and 5 leave `ipl` unchanged.
- R9: A `req_valid` raised while `busy` is high is ignored. Its kind, priority and parity change neither the running sequence's length nor its IPL result.
- R10: `seq_done` is high for exactly one cycle, with `busy` low in that cycle. `ipl` changes only in a cycle in which `seq_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_kind | input | 3 | Source kind (0 maskable, 1 fixed level, 2 software, 3 address match, 4 single step, 5 debug) |
| req_prio | input | 3 | Priority of a maskable request |
| vec_lsb | input | 1 | Least significant bit of the vector address |
| sp_lsb | input | 1 | Least significant bit of the stack pointer |
| bus_narrow | input | 1 | 1 selects the 8-bit bus, 0 the 16-bit bus |
| instr_done | input | 1 | Current instruction has completed |
| busy | output | 1 | Request accepted and not yet finished |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| ipl | output | 3 | Interrupt priority level register |

## Verification
The bench builds the block with its default parameters: a 16-bit base of 18 cycles, an 8-bit length of 20, debug and trap extensions of 2 and 1, and a fixed level of 7. It reaches every parity pair on both bus widths and every source kind, up to the 22-cycle debug maximum. Wait times run from zero up to the 30-cycle worst instruction. Stray requests are injected while the block is waiting and while it is counting. This shows that they alter neither the length nor the IPL. A reset in the middle of a sequence shows that an elevated level returns to 0.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;

    typedef enum logic [2:0] {
        K_MASKABLE  = 3'd0,
        K_FIXED     = 3'd1,
        K_SOFTWARE  = 3'd2,
        K_ADDRMATCH = 3'd3,
        K_STEP      = 3'd4,
        K_DEBUG     = 3'd5
    } src_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEQ  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [2:0] kind;
        logic [2:0] prio;
        logic       vec_odd;
        logic       sp_odd;
        logic       narrow;
    } req_t;

    // Extra cycles a source kind adds on top of the bus/parity base.
    function automatic int unsigned kind_extra(input logic [2:0] kind,
                                               input int unsigned dbg_add,
                                               input int unsigned trap_add);
        case (kind)
            K_DEBUG:           return dbg_add;
            K_ADDRMATCH,
            K_STEP:            return trap_add;
            default:           return 0;
        endcase
    endfunction

endpackage

// File: rtl/int_seq_len.sv
module int_seq_len
    import int_seq_pkg::*;
#(
    parameter int unsigned WIDE_BASE  = 18,
    parameter int unsigned NARROW_LEN = 20,
    parameter int unsigned DBG_ADD    = 2,
    parameter int unsigned TRAP_ADD   = 1,
    parameter int unsigned CNT_W      = 5
) (
    input  req_t             req,
    output logic [CNT_W-1:0] len
);
    int unsigned base_len;
    int unsigned total_len;

    always_comb begin
        if (req.narrow) begin
            base_len = NARROW_LEN;
        end else begin
            base_len = WIDE_BASE + int'(req.vec_odd) + int'(req.sp_odd);
        end
        total_len = base_len + kind_extra(req.kind, DBG_ADD, TRAP_ADD);
        len       = total_len[CNT_W-1:0];
    end
endmodule

// File: rtl/int_seq_ipl.sv
module int_seq_ipl
    import int_seq_pkg::*;
#(
    parameter int unsigned IPL_W       = 3,
    parameter int unsigned FIXED_LEVEL = 7
) (
    input  req_t             req,
    input  logic [IPL_W-1:0] cur_ipl,
    output logic [IPL_W-1:0] next_ipl
);
    localparam logic [IPL_W-1:0] FIXED_VAL = IPL_W'(FIXED_LEVEL);

    always_comb begin
        case (req.kind)
            K_MASKABLE: next_ipl = IPL_W'(req.prio);
            K_FIXED:    next_ipl = FIXED_VAL;
            default:    next_ipl = cur_ipl;
        endcase
    end
endmodule

// File: rtl/int_seq_ctrl.sv
module int_seq_ctrl
    import int_seq_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             instr_done,
    input  logic [CNT_W-1:0] seq_len,
    output logic             accept,
    output logic             finish,
    output logic             busy
);
    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy   = (state_q != ST_IDLE);
    assign accept = (state_q == ST_IDLE) && req_valid;
    assign finish = (state_q == ST_SEQ) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (instr_done) begin
                        state_q <= ST_SEQ;
                        cnt_q   <= seq_len - 1'b1;
                    end
                end
                ST_SEQ: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/int_accept_seq.sv
module int_accept_seq
    import int_seq_pkg::*;
#(
    parameter int unsigned IPL_W       = 3,
    parameter int unsigned WIDE_BASE   = 18,
    parameter int unsigned NARROW_LEN  = 20,
    parameter int unsigned DBG_ADD     = 2,
    parameter int unsigned TRAP_ADD    = 1,
    parameter int unsigned FIXED_LEVEL = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [2:0]       req_prio,
    input  logic             vec_lsb,
    input  logic             sp_lsb,
    input  logic             bus_narrow,
    input  logic             instr_done,
    output logic             busy,
    output logic             seq_done,
    output logic [IPL_W-1:0] ipl
);
    localparam int unsigned WIDE_MAX = WIDE_BASE + 2;
    localparam int unsigned BASE_MAX = (WIDE_MAX > NARROW_LEN) ? WIDE_MAX : NARROW_LEN;
    localparam int unsigned ADD_MAX  = (DBG_ADD > TRAP_ADD) ? DBG_ADD : TRAP_ADD;
    localparam int unsigned MAX_LEN  = BASE_MAX + ADD_MAX;
    localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);

    req_t             req_q;
    req_t             req_in;
    logic [CNT_W-1:0] seq_len;
    logic [IPL_W-1:0] ipl_q;
    logic [IPL_W-1:0] ipl_next;
    logic             done_q;
    logic             accept;
    logic             finish;

    always_comb begin
        req_in.kind    = req_kind;
        req_in.prio    = req_prio;
        req_in.vec_odd = vec_lsb;
        req_in.sp_odd  = sp_lsb;
        req_in.narrow  = bus_narrow;
    end

    int_seq_ctrl #(
        .CNT_W(CNT_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .instr_done (instr_done),
        .seq_len    (seq_len),
        .accept     (accept),
        .finish     (finish),
        .busy       (busy)
    );

    int_seq_len #(
        .WIDE_BASE (WIDE_BASE),
        .NARROW_LEN(NARROW_LEN),
        .DBG_ADD   (DBG_ADD),
        .TRAP_ADD  (TRAP_ADD),
        .CNT_W     (CNT_W)
    ) len_i (
        .req (req_q),
        .len (seq_len)
    );

    int_seq_ipl #(
        .IPL_W      (IPL_W),
        .FIXED_LEVEL(FIXED_LEVEL)
    ) ipl_i (
        .req     (req_q),
        .cur_ipl (ipl_q),
        .next_ipl(ipl_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            ipl_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                req_q <= req_in;
            end
            if (finish) begin
                ipl_q <= ipl_next;
            end
        end
    end

    assign seq_done = done_q;
    assign ipl      = ipl_q;
endmodule

// File: rtl/int_accept_seq_chk.sv
module int_accept_seq_chk #(
    parameter int unsigned IPL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [2:0]       req_kind,
    input logic             instr_done,
    input logic             busy,
    input logic             seq_done,
    input logic [IPL_W-1:0] ipl
);
    logic [2:0] kind_q;
    logic       started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q    <= '0;
            started_q <= 1'b0;
        end else begin
            if (!busy && req_valid) begin
                kind_q    <= req_kind;
                started_q <= 1'b0;
            end else if (busy && instr_done) begin
                started_q <= 1'b1;
            end
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!busy && !seq_done && ipl == '0));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    p_busy_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    p_waits_instr_r2: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> started_q);

    p_fixed_level_r7: assert property (@(posedge clk) disable iff (rst)
        (seq_done && kind_q == 3'd1) |-> (ipl == IPL_W'(7)));

    p_keep_level_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_done && kind_q >= 3'd2) |-> $stable(ipl));

    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    p_idle_on_done_r10: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> !busy);

    p_ipl_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !seq_done |-> $stable(ipl));
endmodule

bind int_accept_seq int_accept_seq_chk #(.IPL_W(IPL_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .instr_done(instr_done),
    .busy      (busy),
    .seq_done  (seq_done),
    .ipl       (ipl)
);

// File: tb/int_accept_seq_tb_top.sv
module int_accept_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [2:0] req_kind;
    logic [2:0] req_prio;
    logic       vec_lsb;
    logic       sp_lsb;
    logic       bus_narrow;
    logic       instr_done;
    logic       busy;
    logic       seq_done;
    logic [2:0] ipl;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    int_accept_seq dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_prio  (req_prio),
        .vec_lsb   (vec_lsb),
        .sp_lsb    (sp_lsb),
        .bus_narrow(bus_narrow),
        .instr_done(instr_done),
        .busy      (busy),
        .seq_done  (seq_done),
        .ipl       (ipl)
    );

    // {kind, prio, vec, sp, narrow, wait, exp_len, exp_ipl}
    localparam int NV = 12;
    localparam logic [22:0] VECS [NV] = '{
        {3'd0, 3'd3, 1'b0, 1'b0, 1'b0, 6'd0,  5'd18, 3'd3},
        {3'd0, 3'd5, 1'b1, 1'b0, 1'b0, 6'd3,  5'd19, 3'd5},
        {3'd2, 3'd1, 1'b0, 1'b1, 1'b0, 6'd30, 5'd19, 3'd5},
        {3'd1, 3'd2, 1'b1, 1'b1, 1'b0, 6'd1,  5'd20, 3'd7},
        {3'd0, 3'd1, 1'b0, 1'b0, 1'b1, 6'd2,  5'd20, 3'd1},
        {3'd3, 3'd6, 1'b1, 1'b1, 1'b1, 6'd4,  5'd21, 3'd1},
        {3'd4, 3'd7, 1'b0, 1'b0, 1'b0, 6'd0,  5'd19, 3'd1},
        {3'd5, 3'd4, 1'b1, 1'b1, 1'b0, 6'd7,  5'd22, 3'd1},
        {3'd5, 3'd4, 1'b0, 1'b0, 1'b1, 6'd1,  5'd22, 3'd1},
        {3'd1, 3'd0, 1'b0, 1'b1, 1'b1, 6'd5,  5'd20, 3'd7},
        {3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 6'd2,  5'd18, 3'd0},
        {3'd4, 3'd3, 1'b1, 1'b0, 1'b0, 6'd1,  5'd20, 3'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    task automatic drive_req(input logic [2:0] k, input logic [2:0] p,
                             input logic v, input logic s, input logic n);
        req_valid  = 1'b1;
        req_kind   = k;
        req_prio   = p;
        vec_lsb    = v;
        sp_lsb     = s;
        bus_narrow = n;
    endtask

    // Runs one request; waits 'wc' cycles before instr_done, checks length and IPL.
    task automatic run_case(input logic [2:0] k, input logic [2:0] p, input logic v,
                            input logic s, input logic n, input int wc,
                            input int exp_len, input int exp_ipl);
        int   cnt;
        logic [2:0] ipl_before;
        @(negedge clk);
        ipl_before = ipl;
        drive_req(k, p, v, s, n);
        @(negedge clk);
        check("R2 busy after accept", int'(busy), 1);
        // stray request with different attributes while waiting (R9)
        drive_req(3'd1, ~p, ~v, ~s, ~n);
        for (int i = 0; i < wc; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (busy !== 1'b1 || seq_done !== 1'b0)
                check("R2 waits for instr_done", int'({busy, seq_done}), 2);
        end
        req_valid  = 1'b0;
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        cnt = 0;
        while (cnt < 60) begin
            if (cnt == 3) drive_req(3'd0, ~p, ~v, ~s, ~n); // stray during count (R9)
            if (cnt == 4) req_valid = 1'b0;
            @(negedge clk);
            cnt++;
            if (seq_done) break;
            if (ipl !== ipl_before) check("R10 ipl holds during sequence", int'(ipl), int'(ipl_before));
        end
        check("R3 R4 R5 R9 sequence length", cnt, exp_len);
        check("R6 R7 R8 R9 ipl result", int'(ipl), exp_ipl);
        check("R10 busy low with done", int'(busy), 0);
        @(negedge clk);
        check("R10 done is one cycle", int'(seq_done), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_kind = '0; req_prio = '0;
        vec_lsb = 1'b0; sp_lsb = 1'b0; bus_narrow = 1'b0; instr_done = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(seq_done), 0);
        check("R1 ipl in reset", int'(ipl), 0);
        rst = 1'b0;

        // R2: instr_done alone does nothing
        instr_done = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R2 idle ignores instr_done", int'({busy, seq_done}), 0);
        end
        instr_done = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [22:0] e;
            e = VECS[i];
            run_case(e[22:20], e[19:17], e[16], e[15], e[14],
                     int'(e[13:8]), int'(e[7:3]), int'(e[2:0]));
        end

        // R1: reset in the middle of a sequence clears an elevated level
        run_case(3'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1, 18, 6);
        @(negedge clk);
        drive_req(3'd1, 3'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 busy after mid reset", int'(busy), 0);
        check("R1 ipl after mid reset", int'(ipl), 0);
        rst = 1'b0;
        repeat (25) @(negedge clk);
        check("R1 abandoned sequence gives no done", int'({busy, seq_done}), 0);
        check("R1 ipl stays 0 after abandon", int'(ipl), 0);

        finish_run();
    end
endmodule